// File: doc/BRIEF.md
# Dual-Mode Capture/Compare Timer

This block is a programmable timer peripheral. Its count register is either a single 16-bit counter or two independent 8-bit counters: a high half (the primary counter) and a low half (the secondary counter). Each counter has its own run bit. When a counter reaches all ones it reloads from the matching part of the reload register. When it equals the matching part of the compare register it sets a compare flag. An optional gate input can freeze counting. In capture mode an external edge snapshots the count and restarts it from the reload value. A single-shot option stops a counter after its first overflow.

Two output pins, A and B, each have an enable and a polarity bit. Enabling a pin loads the polarity value into it. After that, the pin toggles on the match and overflow events of the counter that feeds it. Pin A follows the primary counter. Pin B follows the primary counter in 16-bit mode and the low counter in split mode. Sticky flags are cleared by software and drive two level interrupt requests. A small single-cycle register bus sets up and reads back all state.

Top module: `dual_timer`

Register map. Reads are combinational. Writes take effect at the clock edge where `bus_we` is high.

- Address 0, control register:
  - bit0: primary run
  - bit1: low run
  - bit2: split mode (1 = two 8-bit counters)
  - bit3: capture mode
  - bit4: single-shot
  - bit5: gate enable
  - bit6: pin A polarity
  - bit7: pin A enable
  - bit8: pin B polarity
  - bit9: pin B enable
  - bit10: primary interrupt enable
  - bit11: secondary interrupt enable
- Address 1, status register. Writing 1 to a bit clears it.
  - bit0: primary overflow
  - bit1: primary compare
  - bit2: low overflow
  - bit3: low compare
- Address 2: reload value.
- Address 3: compare value.
- Address 4: capture value (read only).
- Address 5: count (read/write).
- Addresses 6 and 7 read as zero.

## Requirements
- R1: After reset every register reads zero, both pins are low and both requests are low.
- R2: In 16-bit mode (control bit2 = 0), while primary run (bit0) is set and the counter is not gated, the count rises by one each cycle. At 16'hFFFF it loads the reload value instead and sets status bit0.
- R3: A counting cycle in which the primary counter equals the compare value sets status bit1. In split mode this compares the count's high byte with the compare value's high byte.
- R4: In split mode the high byte (run bit0) and the low byte (run bit1) count independently. Each reloads from its own byte of the reload value after reaching 8'hFF. The low counter sets status bit2 on overflow and bit3 on a match with the compare value's low byte. Bit1 has no effect in 16-bit mode.
- R5: With gate enable (bit5) set, counting happens only while `gate_in`, passed through two flops, is high.
- R6: With single-shot (bit4) set, an overflow clears the run bit of the counter that overflowed.
- R7: In capture mode (bit3 = 1), a rising edge of `cap_in`, detected on its two-flop synchronized copy, copies the count to address 4 and loads the reload value into the count. With bit3 = 0 the edge changes neither the capture value nor the count.
- R8: A control write that changes a pin's enable from 0 to 1 sets that pin to the written polarity bit. Later polarity writes do not change the pin. A disabled pin reads 0.
- R9: An enabled pin toggles once per counting cycle in which its source counter overflows, matches, or both. Pin A follows the primary counter. Pin B follows the primary counter in 16-bit mode and the low counter in split mode.
- R10: Status bits stay set until a status write with a 1 in that bit clears them. A hardware set in the same cycle wins over the clear.
- R11: `irq_a` is high while bit10 is set and status bit0 or bit1 is set. `irq_b` is high while split mode, bit11 and status bit2 or bit3 are all set.
- R12: A bus write to the count wins over counting and capture in the same cycle. Reload, compare and count read back at their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| gate_in | input | 1 | Asynchronous count gate |
| cap_in | input | 1 | Asynchronous capture trigger |
| out_a | output | 1 | Pin A |
| out_b | output | 1 | Pin B |
| irq_a | output | 1 | Primary interrupt request |
| irq_b | output | 1 | Secondary interrupt request |

## Verification
A wrong count or a missed reload shows in the count readback within one cycle, and again later through mistimed flags and pin toggles. A misplaced event leaves a pin with the opposite phase for every cycle after it, so one error in the pin state never heals on its own. A wrong flag or enable shows at once on the request lines. The bench uses a cycle model to compare every output on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/dual_timer.sv
`timescale 1ns/1ps
module dual_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          gate_in,
  input  logic          cap_in,
  output logic          out_a,
  output logic          out_b,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int HW = CW / 2;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_RLD = 3'd2,
                         A_CMP = 3'd3, A_CAP = 3'd4, A_CNT = 3'd5;
  localparam logic [CW-1:0] ONE  = 1;
  localparam logic [HW-1:0] HONE = 1;

  logic [11:0]   ctrl;
  logic [3:0]    st;
  logic [CW-1:0] rld, cmpv, capv, cnt, cnt_nx;
  logic          pa, pb;
  logic [1:0]    gsy;
  logic [2:0]    csy;

  logic run_hi, run_lo, split, capm, oneshot, gate_en;
  logic oe_a, oe_b, ie_a, ie_b;
  assign run_hi  = ctrl[0];
  assign run_lo  = ctrl[1];
  assign split   = ctrl[2];
  assign capm    = ctrl[3];
  assign oneshot = ctrl[4];
  assign gate_en = ctrl[5];
  assign oe_a    = ctrl[7];
  assign oe_b    = ctrl[9];
  assign ie_a    = ctrl[10];
  assign ie_b    = ctrl[11];

  logic w_ctrl, w_stat, w_rld, w_cmp, w_cnt;
  assign w_ctrl = bus_we && bus_addr == A_CTRL;
  assign w_stat = bus_we && bus_addr == A_STAT;
  assign w_rld  = bus_we && bus_addr == A_RLD;
  assign w_cmp  = bus_we && bus_addr == A_CMP;
  assign w_cnt  = bus_we && bus_addr == A_CNT;

  logic gate_ok, cap_edge, adv_hi, adv_lo;
  assign gate_ok  = !gate_en || gsy[1];
  assign cap_edge = capm && csy[1] && !csy[2];
  assign adv_hi   = run_hi && gate_ok;
  assign adv_lo   = split && run_lo && gate_ok;

  logic ovf_hi, cmp_hi, ovf_lo, cmp_lo, ev_a, ev_b;
  assign ovf_hi = adv_hi && (split ? &cnt[CW-1:HW] : &cnt);
  assign cmp_hi = adv_hi && (split ? cnt[CW-1:HW] == cmpv[CW-1:HW] : cnt == cmpv);
  assign ovf_lo = adv_lo && &cnt[HW-1:0];
  assign cmp_lo = adv_lo && cnt[HW-1:0] == cmpv[HW-1:0];
  assign ev_a   = ovf_hi || cmp_hi;
  assign ev_b   = split ? (ovf_lo || cmp_lo) : ev_a;

  always_comb begin
    cnt_nx = cnt;
    if (!split) begin
      if (adv_hi) cnt_nx = ovf_hi ? rld : cnt + ONE;
    end else begin
      if (adv_hi) cnt_nx[CW-1:HW] = ovf_hi ? rld[CW-1:HW] : cnt[CW-1:HW] + HONE;
      if (adv_lo) cnt_nx[HW-1:0]  = ovf_lo ? rld[HW-1:0]  : cnt[HW-1:0] + HONE;
    end
    if (cap_edge) cnt_nx = rld;
    if (w_cnt)    cnt_nx = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gsy <= '0;
      csy <= '0;
    end else begin
      gsy <= {gsy[0], gate_in};
      csy <= {csy[1:0], cap_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (w_ctrl) begin
      ctrl <= bus_wdata[11:0];
    end else begin
      if (oneshot && ovf_hi) ctrl[0] <= 1'b0;
      if (oneshot && ovf_lo) ctrl[1] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= '0;
      rld  <= '0;
      cmpv <= '0;
      capv <= '0;
      cnt  <= '0;
    end else begin
      st  <= (st & ~(w_stat ? bus_wdata[3:0] : 4'b0)) | {cmp_lo, ovf_lo, cmp_hi, ovf_hi};
      cnt <= cnt_nx;
      if (w_rld)    rld  <= bus_wdata;
      if (w_cmp)    cmpv <= bus_wdata;
      if (cap_edge) capv <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa <= 1'b0;
      pb <= 1'b0;
    end else begin
      if (w_ctrl && bus_wdata[7] && !oe_a) pa <= bus_wdata[6];
      else if (oe_a && ev_a)               pa <= ~pa;
      if (w_ctrl && bus_wdata[9] && !oe_b) pb <= bus_wdata[8];
      else if (oe_b && ev_b)               pb <= ~pb;
    end
  end

  assign out_a = oe_a && pa;
  assign out_b = oe_b && pb;
  assign irq_a = ie_a && (st[0] || st[1]);
  assign irq_b = split && ie_b && (st[2] || st[3]);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(CW-12){1'b0}}, ctrl};
      A_STAT:  bus_rdata = {{(CW-4){1'b0}}, st};
      A_RLD:   bus_rdata = rld;
      A_CMP:   bus_rdata = cmpv;
      A_CAP:   bus_rdata = capv;
      A_CNT:   bus_rdata = cnt;
      default: bus_rdata = '0;
    endcase
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && ovf_hi && !cap_edge && !w_cnt) |=> (cnt == $past(rld)));
  p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gsy[1] && !cap_edge && !w_cnt) |=> $stable(cnt));
  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && ovf_hi && !w_ctrl) |=> !run_hi);
  p_oe_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && bus_wdata[7] && !oe_a) |=> (out_a == $past(bus_wdata[6])));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st[1] && !(w_stat && bus_wdata[1])) |=> st[1]);
  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_a && st[0] && !w_ctrl && !(w_stat && bus_wdata[0])) |=> irq_a);
endmodule

// File: tb/dual_timer_tb.sv
`timescale 1ns/1ps
module dual_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        gate_in = 1'b0, cap_in = 1'b0;
  logic        out_a, out_b, irq_a, irq_b;

  dual_timer #(.CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_in(gate_in),
    .cap_in(cap_in), .out_a(out_a), .out_b(out_b), .irq_a(irq_a), .irq_b(irq_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic [15:0] rd;

  logic [11:0] m_ctrl;
  logic [3:0]  m_st;
  logic [15:0] m_rld, m_cmp, m_cap, m_cnt;
  logic        m_pa, m_pb;
  logic [1:0]  m_g;
  logic [2:0]  m_c;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {4'd0, m_ctrl};
      3'd1: return {12'd0, m_st};
      3'd2: return m_rld;
      3'd3: return m_cmp;
      3'd4: return m_cap;
      3'd5: return m_cnt;
      default: return 16'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R6";
      3'd1: return "R10";
      3'd4: return "R7";
      3'd5: return "R2";
      default: return "R12";
    endcase
  endfunction

  task automatic mreset();
    m_ctrl = '0; m_st = '0; m_rld = '0; m_cmp = '0; m_cap = '0; m_cnt = '0;
    m_pa = 0; m_pb = 0; m_g = '0; m_c = '0;
  endtask

  task automatic mstep(input logic we, input logic [2:0] a, input logic [15:0] wd,
                       input logic g, input logic c);
    logic sp, gok, ce, ah, al, oh, ch, ol, cl, ea, eb;
    logic [15:0] nc;
    sp  = m_ctrl[2];
    gok = !m_ctrl[5] || m_g[1];
    ce  = m_ctrl[3] && m_c[1] && !m_c[2];
    ah  = m_ctrl[0] && gok;
    al  = sp && m_ctrl[1] && gok;
    if (sp) begin
      oh = ah && m_cnt[15:8] == 8'hFF;
      ch = ah && m_cnt[15:8] == m_cmp[15:8];
    end else begin
      oh = ah && m_cnt == 16'hFFFF;
      ch = ah && m_cnt == m_cmp;
    end
    ol = al && m_cnt[7:0] == 8'hFF;
    cl = al && m_cnt[7:0] == m_cmp[7:0];
    ea = oh || ch;
    eb = sp ? (ol || cl) : ea;
    nc = m_cnt;
    if (!sp) begin
      if (ah) nc = oh ? m_rld : m_cnt + 16'd1;
    end else begin
      if (ah) nc[15:8] = oh ? m_rld[15:8] : m_cnt[15:8] + 8'd1;
      if (al) nc[7:0]  = ol ? m_rld[7:0]  : m_cnt[7:0] + 8'd1;
    end
    if (ce) begin m_cap = m_cnt; nc = m_rld; end
    if (we && a == 3'd5) nc = wd;
    m_cnt = nc;
    m_st = (m_st & ~((we && a == 3'd1) ? wd[3:0] : 4'd0)) | {cl, ol, ch, oh};
    if (we && a == 3'd0 && wd[7] && !m_ctrl[7]) m_pa = wd[6];
    else if (m_ctrl[7] && ea) m_pa = ~m_pa;
    if (we && a == 3'd0 && wd[9] && !m_ctrl[9]) m_pb = wd[8];
    else if (m_ctrl[9] && eb) m_pb = ~m_pb;
    if (we && a == 3'd0) m_ctrl = wd[11:0];
    else begin
      if (m_ctrl[4] && oh) m_ctrl[0] = 1'b0;
      if (m_ctrl[4] && ol) m_ctrl[1] = 1'b0;
    end
    if (we && a == 3'd2) m_rld = wd;
    if (we && a == 3'd3) m_cmp = wd;
    m_g = {m_g[0], g};
    m_c = {m_c[1:0], c};
  endtask

  // one cycle: drive at negedge, check, clock, step model
  task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] wd,
                     input logic g, input logic c);
    bus_we = we; bus_addr = a; bus_wdata = wd; gate_in = g; cap_in = c;
    #1;
    rd = bus_rdata;
    chk(rd_tag(a), bus_rdata, exp_rd(a));
    chk("R9", {15'd0, out_a}, {15'd0, m_ctrl[7] & m_pa});
    chk("R9", {15'd0, out_b}, {15'd0, m_ctrl[9] & m_pb});
    chk("R11", {15'd0, irq_a}, {15'd0, m_ctrl[10] & (m_st[0] | m_st[1])});
    chk("R11", {15'd0, irq_b}, {15'd0, m_ctrl[2] & m_ctrl[11] & (m_st[2] | m_st[3])});
    @(posedge clk);
    mstep(we, a, wd, g, c);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] wd);
    cyc(1'b1, a, wd, gate_in, cap_in);
  endtask

  task automatic rdc(input logic [2:0] a);
    cyc(1'b0, a, 16'd0, gate_in, cap_in);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd5, 16'd0, gate_in, cap_in);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 0; gate_in = 0; cap_in = 0;
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int cyc_n = 0;
    while (!done && cyc_n < 60000) begin @(posedge clk); cyc_n++; end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all R) actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    void'($urandom(32'h5EED));
    do_reset();
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rdc(3'(a));
      chk("R1", rd, 16'd0);
    end
    chk("R1", {12'd0, out_a, out_b, irq_a, irq_b}, 16'd0);

    // R8: enable loads polarity; later polarity change ignored
    wr(3'd0, 16'h00C0);
    rdc(3'd0);
    chk("R8", {15'd0, out_a}, 16'd1);
    wr(3'd0, 16'h0080);
    idle(2);
    chk("R8", {15'd0, out_a}, 16'd1);
    wr(3'd0, 16'h0000);
    chk("R8", {15'd0, out_a}, 16'd0);

    // R3: compare flag in 16-bit mode
    wr(3'd5, 16'd3);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'h0401);
    idle(6);
    rdc(3'd1);
    chk("R3", rd & 16'h2, 16'h2);
    chk("R11", {15'd0, irq_a}, 16'd1);
    wr(3'd1, 16'h000F);
    rdc(3'd1);
    chk("R10", rd, 16'd0);

    // R2: wrap to reload and overflow flag
    wr(3'd2, 16'h1234);
    wr(3'd5, 16'hFFFC);
    idle(6);
    rdc(3'd1);
    chk("R2", rd & 16'h1, 16'h1);

    // R6: single-shot stops primary
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'hFFFD);
    wr(3'd0, 16'h0011);
    idle(8);
    rdc(3'd0);
    chk("R6", rd & 16'h1, 16'h0);

    // R5: gate low freezes count
    gate_in = 1'b0;
    wr(3'd0, 16'h0021);
    idle(3);
    rdc(3'd5); snap = rd;
    idle(4);
    rdc(3'd5);
    chk("R5", rd, snap);
    gate_in = 1'b1;
    idle(4);
    rdc(3'd5);
    chk("R5", {15'd0, rd != snap}, 16'd1);

    // R4: split mode, only low counter runs
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0206);
    idle(300);
    rdc(3'd5);
    chk("R4", rd & 16'hFF00, 16'h0000);
    rdc(3'd1);
    chk("R4", rd & 16'h4, 16'h4);

    // R7: capture edge ignored in compare mode, honoured in capture mode
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h0042);
    cap_in = 1'b1; idle(4); cap_in = 1'b0; idle(2);
    rdc(3'd4);
    chk("R7", rd, 16'h0000);
    rdc(3'd5);
    chk("R7", rd, 16'h0042);
    wr(3'd2, 16'h0100);
    wr(3'd0, 16'h0008);
    cap_in = 1'b1; idle(4); cap_in = 1'b0; idle(2);
    rdc(3'd4);
    chk("R7", rd, 16'h0042);
    rdc(3'd5);
    chk("R12", rd, 16'h0100);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic we;
      logic [2:0] a;
      logic [15:0] wd;
      we = ($urandom % 5) == 0;
      a  = 3'($urandom % 8);
      wd = 16'($urandom);
      if (we && a == 3'd5) wd = ($urandom % 2) ? (16'hFFE0 | wd[4:0]) : {wd[15:8], 8'hF0 | wd[3:0]};
      if (we && a == 3'd0 && ($urandom % 3) != 0) wd[4] = 1'b0;
      if (we && a == 3'd0) wd[1:0] = 2'b11 & (wd[1:0] | 2'($urandom % 4));
      if (($urandom % 16) == 0) gate_in = ~gate_in;
      if (($urandom % 12) == 0) cap_in = ~cap_in;
      cyc(we, a, wd, gate_in, cap_in);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule